// File: doc/BRIEF.md
# SDRAM refresh and low-power sequencer

This block sits on the controller side of an SDRAM interface. It keeps the memory refreshed and steps it through its low-power states. An interval timer adds one owed refresh every `REFI_CYC` clocks. By default that interval is derived from a clock-rate parameter as 64 ms divided by 8192, which is about 781 cycles at 100 MHz. Owed refreshes are held in a small counter so the main access scheduler is not interrupted on every tick. They are paid off early when the scheduler reports it has nothing queued. When the counter fills, the block takes the bus by force.

To issue a refresh, the sequencer withdraws its grant to the access scheduler and waits until every bank reports idle. It then drives one auto-refresh command and holds the scheduler off for a full row-cycle time. Self-refresh and power-down requests are handled in the same way: the block drives the clock-enable pin and the command pins in the required order and enforces the wait that follows each exit. A separate request line asks the scheduler to rewrite the mode register after power-up and after any deep power-down exit.

Command pins are active low and are presented as {csN,rasN,casN,weN}. The no-op pattern is 4'b0111 and the refresh pattern is 4'b0001. Bank activation, reads, writes and the data path belong to other blocks.

Top module: `rfsq_top`

## Requirements
- R1: Each `REFI_CYC` clocks one refresh becomes owed. With self-refresh unused, the refreshes issued over any span fall short of span/`REFI_CYC` by at most 2*`OWED_MAX`+1.
- R2: A refresh is the pattern 4'b0001 on {csN,rasN,casN,weN} with cke high. It appears only in the cycle after allBanksIdle was high, and only while accessGrant is low. While allBanksIdle stays low the pins hold no-op.
- R3: In the `TRC_CYC`-1 cycles that follow a refresh command, accessGrant is low and busy is high. accessGrant returns high exactly `TRC_CYC` cycles after the command cycle.
- R4: When the owed count reaches `OWED_MAX`, accessGrant drops even if schedQuiet is low, and a pending power-down is left for this. With schedQuiet high and at least one refresh owed, refreshes are issued early.
- R5: A self-refresh request first drops accessGrant and waits for allBanksIdle. It then drives the refresh pattern with cke low in the same cycle.
- R6: cke stays low for as long as srReq is held, and the pins carry no refresh pattern meanwhile. When srReq is released, one cycle shows cke high with the no-op pattern. accessGrant then returns `TRC_CYC` cycles after that exit cycle.
- R7: Self-refresh exit clears both the interval timer and the owed count. The next forced stall comes `OWED_MAX`*`REFI_CYC` to that plus 3 cycles after the exit cycle.
- R8: With no refresh due, pdReq high and burstActive low bring cke and accessGrant low in the next cycle. While burstActive is high, power-down is not entered.
- R9: When pdReq drops, the first cycle shows cke high with accessGrant low. accessGrant is high in the cycle after.
- R10: mrsReq is high after reset and is cleared in the cycle after mrsDone. dpdExit sets it in the cycle after, and dpdExit wins when both are high.
- R11: Out of reset, cke is 1, the pins show no-op, accessGrant is 1 and busy is 0.
- R12: accessGrant and busy are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allBanksIdle | input | 1 | Every bank is precharged and idle |
| schedQuiet | input | 1 | Access scheduler has nothing queued |
| srReq | input | 1 | Level request to stay in self-refresh |
| pdReq | input | 1 | Level request to stay in power-down |
| burstActive | input | 1 | A data burst is in progress |
| dpdExit | input | 1 | Pulse: the device has left deep power-down |
| mrsDone | input | 1 | Pulse: the scheduler has written the mode register |
| cke | output | 1 | Clock enable to the SDRAM |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| accessGrant | output | 1 | Scheduler may issue commands this cycle |
| busy | output | 1 | Sequencer holds the bus (drain or blackout) |
| mrsReq | output | 1 | Mode register must be rewritten |

## Verification
A wrong owed count or a timer that is not cleared shows up at the ports as a forced stall at the wrong time. The clearest case is right after self-refresh: the stall then comes within a few cycles instead of `OWED_MAX`*`REFI_CYC` cycles later. A wrong blackout count moves the rise of accessGrant away from exactly `TRC_CYC` cycles after the refresh or exit cycle, and this is visible within that window. A wrong state in the sequencing FSM shows at once: a refresh pattern while allBanksIdle was low, cke rising with the grant already high, or grant and busy high together.

// File: rtl/rfsq_pkg.sv
package rfsq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DRAIN_REF,
    ST_DRAIN_SR,
    ST_REF,
    ST_SR_ENTER,
    ST_SR_HOLD,
    ST_SR_EXIT,
    ST_BLACKOUT,
    ST_PD,
    ST_PD_EXIT
  } rfsq_state_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic refIssue;   // one owed refresh paid
    logic srExit;     // clear timer and owed count
    logic trcLoad;    // start a row-cycle blackout
  } rfsq_strobe_t;

  // Status from datapath to control.
  typedef struct packed {
    logic owedAny;
    logic owedFull;
    logic trcDone;
  } rfsq_status_t;

  // Command pins, active low.
  typedef struct packed {
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
  } rfsq_cmd_t;

  localparam rfsq_cmd_t CMD_NOP     = '{csN: 1'b0, rasN: 1'b1, casN: 1'b1, weN: 1'b1};
  localparam rfsq_cmd_t CMD_REFRESH = '{csN: 1'b0, rasN: 1'b0, casN: 1'b0, weN: 1'b1};

endpackage

// File: rtl/rfsq_dp.sv
module rfsq_dp
  import rfsq_pkg::*;
#(
  parameter int REFI_CYC = 781,
  parameter int TRC_CYC  = 7,
  parameter int OWED_MAX = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  rfsq_strobe_t stb,
  output rfsq_status_t sts
);

  localparam int REFI_W = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
  localparam int TRC_W  = (TRC_CYC > 2) ? $clog2(TRC_CYC) : 1;
  localparam int OWED_W = $clog2(OWED_MAX + 1);

  localparam logic [REFI_W-1:0] REFI_LAST = REFI_W'(REFI_CYC - 1);
  localparam logic [TRC_W-1:0]  TRC_LOAD  = TRC_W'(TRC_CYC - 2);
  localparam logic [OWED_W-1:0] OWED_TOP  = OWED_W'(OWED_MAX);

  logic [REFI_W-1:0] intervalCnt;
  logic [OWED_W-1:0] owedCnt;
  logic [TRC_W-1:0]  trcCnt;
  logic              intervalTick;

  assign intervalTick = (intervalCnt == REFI_LAST);

  // Refresh-interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (stb.srExit || intervalTick) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + REFI_W'(1);
    end
  end

  // Owed-refresh count, saturating at OWED_MAX
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owedCnt <= '0;
    end else if (stb.srExit) begin
      owedCnt <= '0;
    end else begin
      unique case ({intervalTick, stb.refIssue})
        2'b10: if (owedCnt != OWED_TOP) owedCnt <= owedCnt + OWED_W'(1);
        2'b01: if (owedCnt != '0)       owedCnt <= owedCnt - OWED_W'(1);
        default: owedCnt <= owedCnt;
      endcase
    end
  end

  // Row-cycle blackout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trcCnt <= '0;
    end else if (stb.trcLoad) begin
      trcCnt <= TRC_LOAD;
    end else if (trcCnt != '0) begin
      trcCnt <= trcCnt - TRC_W'(1);
    end
  end

  assign sts.owedAny  = (owedCnt != '0);
  assign sts.owedFull = (owedCnt == OWED_TOP);
  assign sts.trcDone  = (trcCnt == '0);

endmodule

// File: rtl/rfsq_ctrl.sv
module rfsq_ctrl
  import rfsq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         allBanksIdle,
  input  logic         schedQuiet,
  input  logic         srReq,
  input  logic         pdReq,
  input  logic         burstActive,
  input  logic         dpdExit,
  input  logic         mrsDone,
  input  rfsq_status_t sts,
  output rfsq_strobe_t stb,
  output rfsq_cmd_t    cmd,
  output logic         cke,
  output logic         grant,
  output logic         busy,
  output logic         mrsReq
);

  rfsq_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // Next state: a forced refresh outranks self-refresh, which outranks
  // an early refresh, which outranks power-down.
  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (sts.owedFull)                  stateNext = ST_DRAIN_REF;
        else if (srReq)                    stateNext = ST_DRAIN_SR;
        else if (sts.owedAny && schedQuiet) stateNext = ST_DRAIN_REF;
        else if (pdReq && !burstActive)    stateNext = ST_PD;
      end
      ST_DRAIN_REF: if (allBanksIdle) stateNext = ST_REF;
      ST_DRAIN_SR:  if (allBanksIdle) stateNext = ST_SR_ENTER;
      ST_REF:       stateNext = ST_BLACKOUT;
      ST_SR_ENTER:  stateNext = ST_SR_HOLD;
      ST_SR_HOLD:   if (!srReq) stateNext = ST_SR_EXIT;
      ST_SR_EXIT:   stateNext = ST_BLACKOUT;
      ST_BLACKOUT:  if (sts.trcDone) stateNext = ST_IDLE;
      ST_PD:        if (!pdReq || sts.owedFull) stateNext = ST_PD_EXIT;
      ST_PD_EXIT:   stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  // Outputs decoded from the registered state
  always_comb begin
    stb   = '0;
    cmd   = CMD_NOP;
    cke   = 1'b1;
    grant = 1'b0;
    busy  = 1'b1;
    unique case (state)
      ST_IDLE: begin
        grant = 1'b1;
        busy  = 1'b0;
      end
      ST_REF: begin
        cmd          = CMD_REFRESH;
        stb.refIssue = 1'b1;
        stb.trcLoad  = 1'b1;
      end
      ST_SR_ENTER: begin
        cmd = CMD_REFRESH;
        cke = 1'b0;
      end
      ST_SR_HOLD: begin
        cke  = 1'b0;
        busy = 1'b0;
      end
      ST_SR_EXIT: begin
        stb.srExit  = 1'b1;
        stb.trcLoad = 1'b1;
      end
      ST_PD: begin
        cke  = 1'b0;
        busy = 1'b0;
      end
      default: ;
    endcase
  end

  // Mode-register rewrite request: set at power-up and on deep power-down exit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        mrsReq <= 1'b1;
    else if (dpdExit) mrsReq <= 1'b1;
    else if (mrsDone) mrsReq <= 1'b0;
  end

endmodule

// File: rtl/rfsq_top.sv
module rfsq_top
  import rfsq_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int REFI_CYC = (64000 * CLK_MHZ) / 8192,
  parameter int TRC_CYC  = 7,
  parameter int OWED_MAX = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic allBanksIdle,
  input  logic schedQuiet,
  input  logic srReq,
  input  logic pdReq,
  input  logic burstActive,
  input  logic dpdExit,
  input  logic mrsDone,
  output logic cke,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic accessGrant,
  output logic busy,
  output logic mrsReq
);

  rfsq_strobe_t stb;
  rfsq_status_t sts;
  rfsq_cmd_t    cmd;

  rfsq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .allBanksIdle (allBanksIdle),
    .schedQuiet   (schedQuiet),
    .srReq        (srReq),
    .pdReq        (pdReq),
    .burstActive  (burstActive),
    .dpdExit      (dpdExit),
    .mrsDone      (mrsDone),
    .sts          (sts),
    .stb          (stb),
    .cmd          (cmd),
    .cke          (cke),
    .grant        (accessGrant),
    .busy         (busy),
    .mrsReq       (mrsReq)
  );

  rfsq_dp #(
    .REFI_CYC (REFI_CYC),
    .TRC_CYC  (TRC_CYC),
    .OWED_MAX (OWED_MAX)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .sts  (sts)
  );

  assign csN  = cmd.csN;
  assign rasN = cmd.rasN;
  assign casN = cmd.casN;
  assign weN  = cmd.weN;

endmodule

// File: rtl/rfsq_checker.sv
module rfsq_checker (
  input logic clk,
  input logic rstN,
  input logic allBanksIdle,
  input logic dpdExit,
  input logic cke,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic accessGrant,
  input logic busy,
  input logic mrsReq
);

  logic refPat;
  assign refPat = !csN && !rasN && !casN && weN;

  // R2: refresh only after banks were idle
  a_r2_ref_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    (refPat && cke) |-> $past(allBanksIdle));

  // R3: refresh opens a blackout
  a_r3_blackout_start: assert property (@(posedge clk) disable iff (!rstN)
    (refPat && cke) |=> (!accessGrant && busy));

  // R5: self-refresh entry keeps cke low next cycle
  a_r5_sr_cke_low: assert property (@(posedge clk) disable iff (!rstN)
    (refPat && !cke) |=> !cke);

  // R6: no refresh pattern while cke stays low
  a_r6_quiet_in_sr: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && !$past(cke)) |-> !refPat);

  // R9: cke wakes with the grant still withheld
  a_r9_wake_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> !accessGrant);

  // R10: deep power-down exit raises the mode-register request
  a_r10_mrs_set: assert property (@(posedge clk) disable iff (!rstN)
    $past(dpdExit) |-> mrsReq);

  // R12: grant and busy exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(accessGrant && busy));

endmodule

bind rfsq_top rfsq_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .allBanksIdle (allBanksIdle),
  .dpdExit      (dpdExit),
  .cke          (cke),
  .csN          (csN),
  .rasN         (rasN),
  .casN         (casN),
  .weN          (weN),
  .accessGrant  (accessGrant),
  .busy         (busy),
  .mrsReq       (mrsReq)
);

// File: tb/rfsq_top_tb.sv
`timescale 1ns/1ps
module rfsq_top_tb;

  localparam int REFI = 40;
  localparam int TRC  = 6;
  localparam int OMAX = 4;
  localparam int RAND_CYC = 4000;

  logic clk = 1'b0;
  logic rstN;
  logic allBanksIdle, schedQuiet, srReq, pdReq, burstActive, dpdExit, mrsDone;
  logic cke, csN, rasN, casN, weN, accessGrant, busy, mrsReq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rfsq_top #(.REFI_CYC(REFI), .TRC_CYC(TRC), .OWED_MAX(OMAX)) u_dut (
    .clk(clk), .rstN(rstN), .allBanksIdle(allBanksIdle), .schedQuiet(schedQuiet),
    .srReq(srReq), .pdReq(pdReq), .burstActive(burstActive), .dpdExit(dpdExit),
    .mrsDone(mrsDone), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .accessGrant(accessGrant), .busy(busy), .mrsReq(mrsReq)
  );

  function automatic bit isRef();
    return (!csN && !rasN && !casN && weN);
  endfunction

  function automatic bit isNop();
    return (!csN && rasN && casN && weN);
  endfunction

  function automatic int pins();
    return int'({cke, csN, rasN, casN, weN, accessGrant, busy});
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at the event cycle; walks the blackout and ends on grant return.
  task automatic blackout(input string tag);
    for (int i = 1; i < TRC; i++) begin
      @(negedge clk);
      check(!accessGrant && busy, tag, {accessGrant, busy}, 2'b01);
    end
    @(negedge clk);
    check(accessGrant == 1'b1, tag, accessGrant, 1);
  endtask

  task automatic waitGrant();
    for (int n = 0; n < 40 && !accessGrant; n++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    int refCnt;
    bit ok;
    int seedDummy;
    bit mrsExp;
    int blackLeft;

    seedDummy = $urandom(32'd2024);
    rstN = 1'b0;
    allBanksIdle = 0; schedQuiet = 0; srReq = 0; pdReq = 0;
    burstActive = 0; dpdExit = 0; mrsDone = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(pins() == 7'b1011110, "R11 reset pins", pins(), 7'b1011110);
    // R10 power-up request
    check(mrsReq == 1'b1, "R10 after reset", mrsReq, 1);
    mrsDone = 1; @(negedge clk); mrsDone = 0;
    check(mrsReq == 1'b0, "R10 cleared", mrsReq, 0);
    dpdExit = 1; mrsDone = 1; @(negedge clk); dpdExit = 0; mrsDone = 0;
    check(mrsReq == 1'b1, "R10 set wins", mrsReq, 1);
    mrsDone = 1; @(negedge clk); mrsDone = 0;
    check(mrsReq == 1'b0, "R10 cleared again", mrsReq, 0);

    // R4 forced drain with a busy scheduler
    n = 0;
    while (accessGrant && n < OMAX * REFI + 50) begin @(negedge clk); n++; end
    check(!accessGrant, "R4 forced drain", accessGrant, 0);
    ok = 1;
    repeat (8) begin
      @(negedge clk);
      if (!(isNop() && busy && !accessGrant)) ok = 0;
    end
    check(ok, "R2 waits for idle banks", pins(), 7'b1011101);
    allBanksIdle = 1;
    @(negedge clk);
    check(isRef() && cke, "R2 refresh issued", pins(), 7'b1000101);
    blackout("R3 blackout after refresh");

    // R4 early refresh while scheduler is quiet
    schedQuiet = 1;
    refCnt = 0;
    repeat (40) begin @(negedge clk); if (isRef() && cke) refCnt++; end
    check(refCnt >= 2, "R4 early refresh", refCnt, 2);
    // R1 pacing with banks always idle
    refCnt = 0;
    repeat (8 * REFI) begin @(negedge clk); if (isRef() && cke) refCnt++; end
    check(refCnt >= 7 && refCnt <= 9, "R1 pacing", refCnt, 8);
    schedQuiet = 0;
    waitGrant();

    // R8 power-down blocked by burst, then entered
    burstActive = 1; pdReq = 1;
    ok = 1;
    repeat (5) begin @(negedge clk); if (!(cke && accessGrant)) ok = 0; end
    check(ok, "R8 burst blocks power-down", {cke, accessGrant}, 2'b11);
    burstActive = 0;
    @(negedge clk);
    check(!cke && !accessGrant, "R8 power-down entry", {cke, accessGrant}, 2'b00);
    ok = 1;
    repeat (8) begin @(negedge clk); if (cke) ok = 0; end
    check(ok, "R8 cke held low", cke, 0);
    pdReq = 0;
    @(negedge clk);
    check(cke && !accessGrant, "R9 exit gap", {cke, accessGrant}, 2'b10);
    @(negedge clk);
    check(accessGrant == 1'b1, "R9 grant after one clock", accessGrant, 1);

    // R4 forced wake from power-down
    pdReq = 1;
    @(negedge clk);
    n = 0;
    while (!cke && n < OMAX * REFI + 50) begin @(negedge clk); n++; end
    check(cke && pdReq, "R4 wake for refresh", cke, 1);
    pdReq = 0;
    n = 0;
    while (!(isRef() && cke) && n < 8) begin @(negedge clk); n++; end
    check(isRef() && cke, "R4 refresh after wake", pins(), 7'b1000101);
    blackout("R3 blackout after wake refresh");

    // R5 self-refresh entry
    allBanksIdle = 0; srReq = 1;
    @(negedge clk);
    check(!accessGrant && cke, "R5 drain before self-refresh", {cke, accessGrant}, 2'b10);
    ok = 1;
    repeat (4) begin @(negedge clk); if (!cke || isRef()) ok = 0; end
    check(ok, "R5 waits for idle banks", pins(), 7'b1011101);
    allBanksIdle = 1;
    @(negedge clk);
    check(isRef() && !cke, "R5 entry pattern", pins(), 7'b0000101);
    allBanksIdle = 0;
    ok = 1;
    repeat (OMAX * REFI + 20) begin @(negedge clk); if (cke || isRef()) ok = 0; end
    check(ok, "R6 held in self-refresh", pins(), 7'b0011100);
    srReq = 0;
    @(negedge clk);
    check(cke && isNop() && !accessGrant, "R6 exit pattern", pins(), 7'b1011101);
    blackout("R6 blackout after exit");
    // R7 owed count and timer restart from exit
    n = TRC;
    while (accessGrant && n < OMAX * REFI + 20) begin @(negedge clk); n++; end
    check(n >= OMAX * REFI && n <= OMAX * REFI + 3, "R7 stall offset", n, OMAX * REFI + 2);
    allBanksIdle = 1;
    waitGrant();
    waitGrant();

    // Random phase
    mrsExp = mrsReq;
    blackLeft = 0;
    refCnt = 0;
    for (int c = 0; c < RAND_CYC; c++) begin
      @(negedge clk);
      if (dpdExit) mrsExp = 1'b1;
      else if (mrsDone) mrsExp = 1'b0;
      check(mrsReq == mrsExp, "R10 random", mrsReq, mrsExp);
      check(!(accessGrant && busy), "R12 exclusive", {accessGrant, busy}, 2'b00);
      if (blackLeft > 0) begin
        check(!accessGrant, "R3 random blackout", accessGrant, 0);
        blackLeft--;
      end
      if (isRef() && cke) begin
        check(allBanksIdle == 1'b1, "R2 random idle", allBanksIdle, 1);
        check(!accessGrant, "R2 random grant low", accessGrant, 0);
        refCnt++;
        blackLeft = TRC - 1;
      end
      allBanksIdle = ($urandom % 10) < 7;
      schedQuiet   = ($urandom % 10) < 3;
      if (($urandom % 20) == 0) pdReq = ~pdReq;
      burstActive  = ($urandom % 4) == 0;
      dpdExit      = ($urandom % 100) == 0;
      mrsDone      = ($urandom % 20) == 0;
    end
    check(refCnt >= RAND_CYC / REFI - 2 * OMAX - 1, "R1 random pacing",
          refCnt, RAND_CYC / REFI);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule